// File: doc/BRIEF.md
# Host Memory Address Region Router

This block sits in the memory path of a host bridge. It decides, for every physical memory request, whether the request belongs to system DRAM or to device space. Two boundaries set the split, and configuration writes load them. The low boundary marks the top of usable DRAM below the 4 GB line, and everything from it up to 4 GB is a low device hole. The upper boundary marks the top of usable DRAM above 4 GB, and everything at or above it is high device space. Device-space requests leave the block on the downstream link by default.

Each request is a one-cycle valid pulse with a 64-bit address. One clock later the block returns the same address together with a one-hot target and a reserved flag. The reserved flag is raised for addresses beyond the implemented physical address width. Both boundaries are held on a 1 MB grid. After reset both are zero, so every request is sent to device space until the boundaries are programmed.

Top module: `arr_router`

## Requirements
- R1: After reset, `rsp_valid` is 0, and both boundaries read as zero. Until they are written, every request below 4 GB goes to the low device target and every request at or above 4 GB goes to the high device target.
- R2: `rsp_valid` is high exactly one cycle after `req_valid`. In that cycle `rsp_addr` equals the request address. Back-to-back requests each give their own response.
- R3: When `rsp_valid` is 1, `rsp_tgt` has exactly one bit set. Bit 0 means DRAM, bit 1 means the low device hole, and bit 2 means high device space.
- R4: A request below 4 GB whose address is below the low boundary goes to DRAM (bit 0).
- R5: A request below 4 GB whose address is at or above the low boundary goes to the low device hole (bit 1).
- R6: A request at or above 4 GB whose address is below the upper boundary goes to DRAM (bit 0). A request at or above the upper boundary goes to high device space (bit 2).
- R7: A request with any address bit at or above `PHYS_W` set raises `rsp_rsvd` and goes to high device space (bit 2).
- R8: Boundaries are compared on a 1 MB grid. Bits [19:0] of `cfg_data` are ignored when a boundary is written. `cfg_sel` = 0 loads the low boundary from bits [31:20]. `cfg_sel` = 1 loads the upper boundary from bits [63:20].
- R9: A configuration write does not affect a request presented in the same cycle. It applies to requests presented from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_sel | input | 1 | 0 selects the low boundary, 1 selects the upper boundary |
| cfg_data | input | 64 | Boundary value as a byte address |
| req_valid | input | 1 | Request pulse |
| req_addr | input | 64 | Request physical address |
| rsp_valid | output | 1 | Routing result valid |
| rsp_addr | output | 64 | Address carried with the result |
| rsp_tgt | output | 3 | One-hot target: bit 0 DRAM, bit 1 low hole, bit 2 high device |
| rsp_rsvd | output | 1 | Address lies in the reserved region |

## Verification
The bench builds the block with its defaults: a 64-bit address, a 1 MB grid (`GRAN_SHIFT` = 20) and `PHYS_W` = 46. With these values the reserved region is reached by random addresses that have any of bits 63:46 set. The 1 MB grid allows boundary-edge addresses one byte below and at each boundary to be produced directly. A random stream of requests mixed with boundary rewrites exercises same-cycle write ordering and back-to-back responses against a bench-side model of the two boundaries.

// File: rtl/arr_pkg.sv
package arr_pkg;

    // One-hot routing target
    typedef enum logic [2:0] {
        TGT_NONE   = 3'b000,
        TGT_DRAM   = 3'b001,
        TGT_DEV_LO = 3'b010,
        TGT_DEV_HI = 3'b100
    } tgt_e;

    // Boundary register select
    typedef enum logic {
        BSEL_LOW  = 1'b0,
        BSEL_HIGH = 1'b1
    } bsel_e;

    // Routing decision carried through the output stage
    typedef struct packed {
        tgt_e tgt;
        logic rsvd;
    } decision_t;

    localparam int unsigned FOURG_BIT = 32;

    function automatic decision_t make_dec(input tgt_e t, input logic r);
        decision_t d;
        d.tgt  = t;
        d.rsvd = r;
        return d;
    endfunction

endpackage

// File: rtl/arr_bound_regs.sv
module arr_bound_regs
    import arr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned GRAN_SHIFT = 20,
    localparam int unsigned LO_W      = FOURG_BIT - GRAN_SHIFT,
    localparam int unsigned HI_W      = ADDR_W - GRAN_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [LO_W-1:0]   lo_bound,
    output logic [HI_W-1:0]   hi_bound
);

    logic unused_gran_bits;
    assign unused_gran_bits = ^cfg_data[GRAN_SHIFT-1:0];

    logic wr_lo, wr_hi;
    assign wr_lo = cfg_we && (bsel_e'(cfg_sel) == BSEL_LOW);
    assign wr_hi = cfg_we && (bsel_e'(cfg_sel) == BSEL_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_bound <= '0;
        end else if (wr_lo) begin
            lo_bound <= cfg_data[FOURG_BIT-1:GRAN_SHIFT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_bound <= '0;
        end else if (wr_hi) begin
            hi_bound <= cfg_data[ADDR_W-1:GRAN_SHIFT];
        end
    end

endmodule

// File: rtl/arr_classify.sv
module arr_classify
    import arr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned GRAN_SHIFT = 20,
    parameter int unsigned PHYS_W     = 46,
    localparam int unsigned LO_W      = FOURG_BIT - GRAN_SHIFT,
    localparam int unsigned HI_W      = ADDR_W - GRAN_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LO_W-1:0]   lo_bound,
    input  logic [HI_W-1:0]   hi_bound,
    output decision_t         dec
);

    logic unused_addr_lo;
    assign unused_addr_lo = ^addr[GRAN_SHIFT-1:0];

    logic beyond_phys;
    generate
        if (PHYS_W < ADDR_W) begin : g_rsvd
            assign beyond_phys = |addr[ADDR_W-1:PHYS_W];
        end else begin : g_no_rsvd
            assign beyond_phys = 1'b0;
        end
    endgenerate

    logic below_4g, lo_in_dram, hi_in_dram;
    assign below_4g   = ~|addr[ADDR_W-1:FOURG_BIT];
    assign lo_in_dram = addr[FOURG_BIT-1:GRAN_SHIFT] < lo_bound;
    assign hi_in_dram = addr[ADDR_W-1:GRAN_SHIFT] < hi_bound;

    always_comb begin
        if (beyond_phys) begin
            dec = make_dec(TGT_DEV_HI, 1'b1);
        end else if (below_4g) begin
            dec = make_dec(lo_in_dram ? TGT_DRAM : TGT_DEV_LO, 1'b0);
        end else begin
            dec = make_dec(hi_in_dram ? TGT_DRAM : TGT_DEV_HI, 1'b0);
        end
    end

endmodule

// File: rtl/arr_out_stage.sv
module arr_out_stage
    import arr_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  decision_t         in_dec,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output decision_t         out_dec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dec   <= make_dec(TGT_NONE, 1'b0);
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dec <= in_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_addr <= in_addr;
        end
    end

endmodule

// File: rtl/arr_router.sv
module arr_router
    import arr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned GRAN_SHIFT = 20,
    parameter int unsigned PHYS_W     = 46,
    localparam int unsigned LO_W      = FOURG_BIT - GRAN_SHIFT,
    localparam int unsigned HI_W      = ADDR_W - GRAN_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_tgt,
    output logic              rsp_rsvd
);

    logic [LO_W-1:0] lo_bound;
    logic [HI_W-1:0] hi_bound;
    decision_t       dec_now;
    decision_t       dec_q;

    arr_bound_regs #(
        .ADDR_W    (ADDR_W),
        .GRAN_SHIFT(GRAN_SHIFT)
    ) u_bounds (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_data(cfg_data),
        .lo_bound(lo_bound),
        .hi_bound(hi_bound)
    );

    arr_classify #(
        .ADDR_W    (ADDR_W),
        .GRAN_SHIFT(GRAN_SHIFT),
        .PHYS_W    (PHYS_W)
    ) u_classify (
        .addr    (req_addr),
        .lo_bound(lo_bound),
        .hi_bound(hi_bound),
        .dec     (dec_now)
    );

    arr_out_stage #(
        .ADDR_W(ADDR_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_addr  (req_addr),
        .in_dec   (dec_now),
        .out_valid(rsp_valid),
        .out_addr (rsp_addr),
        .out_dec  (dec_q)
    );

    assign rsp_tgt  = dec_q.tgt;
    assign rsp_rsvd = dec_q.rsvd;

endmodule

// File: rtl/arr_router_chk.sv
module arr_router_chk #(
    parameter int unsigned ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [2:0]        rsp_tgt,
    input logic              rsp_rsvd
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    addr_carried_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_addr == $past(req_addr)));

    // R3
    onehot_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones(rsp_tgt) == 1));

    // R7
    rsvd_to_dev_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rsvd) |-> (rsp_tgt == 3'b100));

    // R5
    low_hole_below_4g_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_tgt[1]) |-> (rsp_addr[ADDR_W-1:32] == '0));

    // R6
    high_dev_above_4g_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_tgt[2]) |-> (rsp_addr[ADDR_W-1:32] != '0));

endmodule

bind arr_router arr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_addr (rsp_addr),
    .rsp_tgt  (rsp_tgt),
    .rsp_rsvd (rsp_rsvd)
);

// File: tb/sim_arr_router.sv
module sim_arr_router;

    localparam int unsigned PHYS_W = 46;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_sel;
    logic [63:0] cfg_data;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_tgt;
    logic        rsp_rsvd;

    int n_tests = 0;
    int n_fail  = 0;

    // model boundaries as full byte addresses on a 1 MB grid
    logic [63:0] m_lo;
    logic [63:0] m_hi;

    always #2.5 clk = ~clk;

    arr_router u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_tgt(rsp_tgt), .rsp_rsvd(rsp_rsvd)
    );

    function automatic logic [3:0] ref_route(input logic [63:0] a,
                                             input logic [63:0] lo,
                                             input logic [63:0] hi);
        // returns {rsvd, tgt}
        if (a >= (64'd1 << PHYS_W)) return {1'b1, 3'b100};
        if (a < 64'h1_0000_0000)    return (a < lo) ? 4'b0001 : 4'b0010;
        return (a < hi) ? 4'b0001 : 4'b0100;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, result checked at following negedge
    task automatic step(input logic rv, input logic [63:0] a,
                        input logic we, input logic sel, input logic [63:0] d,
                        input string req);
        logic [3:0] exp;
        req_valid = rv; req_addr = a;
        cfg_we = we; cfg_sel = sel; cfg_data = d;
        exp = ref_route(a, m_lo, m_hi);
        @(posedge clk);
        if (we) begin
            if (sel) m_hi = {d[63:20], 20'h0};
            else     m_lo = {32'h0, d[31:20], 20'h0};
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check({req, " valid"}, {63'h0, rsp_valid}, {63'h0, rv});
        if (rv) begin
            check({req, " addr"}, rsp_addr, a);
            check({req, " route"}, {60'h0, rsp_rsvd, rsp_tgt}, {60'h0, exp});
        end
    endtask

    task automatic wr(input logic sel, input logic [63:0] d);
        step(1'b0, 64'h0, 1'b1, sel, d, "R8 write");
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = '0;
        req_valid = 1'b0; req_addr = '0;
        m_lo = '0; m_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", {63'h0, rsp_valid}, 64'h0);

        // R1 unprogrammed routing
        step(1, 64'h0, 0, 0, 0, "R1 zero addr");
        step(1, 64'hFFFF_FFFF, 0, 0, 0, "R1 top of 4G");
        step(1, 64'h1_0000_0000, 0, 0, 0, "R1 at 4G");

        // program: low = 3 GB (low bits nonzero, must be ignored, R8), upper = 9 GB
        wr(0, 64'hC00F_FFFF);
        wr(1, 64'h2_4000_0000);
        step(1, 64'hBFFF_FFFF, 0, 0, 0, "R4 below low");
        step(1, 64'hC000_0000, 0, 0, 0, "R5 at low");
        step(1, 64'hC00F_FFFF, 0, 0, 0, "R8 inside grain");
        step(1, 64'hFFFF_FFFF, 0, 0, 0, "R5 top of hole");
        step(1, 64'h1_0000_0000, 0, 0, 0, "R6 at 4G");
        step(1, 64'h2_3FFF_FFFF, 0, 0, 0, "R6 below upper");
        step(1, 64'h2_4000_0000, 0, 0, 0, "R6 at upper");
        step(1, 64'h0004_0000_0000_0000, 0, 0, 0, "R7 reserved");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R7 all ones");

        // R9 same-cycle write uses old boundary, next cycle new one
        step(1, 64'h9000_0000, 1, 0, 64'h8000_0000, "R9 same cycle");
        step(1, 64'h9000_0000, 0, 0, 0, "R9 next cycle");
        step(1, 64'h3_0000_0000, 1, 1, 64'h4_0000_0000, "R9 same cycle hi");
        step(1, 64'h3_0000_0000, 0, 0, 0, "R9 next cycle hi");

        // R2 R3 random back-to-back traffic with occasional rewrites
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a;
            logic [2:0]  kind;
            kind = 3'($urandom_range(0, 5));
            case (kind)
                3'd0: a = {32'h0, $urandom()};
                3'd1: a = m_lo + 64'($signed($urandom_range(0, 2)) - 1);
                3'd2: a = m_hi + 64'($signed($urandom_range(0, 2)) - 1);
                3'd3: a = {$urandom(), $urandom()};
                3'd4: a = {16'h0, $urandom_range(0, 65535) & 32'hFFFF, $urandom()};
                default: a = {30'h0, 2'($urandom_range(0, 3)), $urandom()};
            endcase
            if ($urandom_range(0, 9) == 0) begin
                logic sel;
                logic [63:0] d;
                sel = 1'($urandom_range(0, 1));
                d = sel ? {24'h0, 8'($urandom_range(0, 63)), $urandom()} : {32'h0, $urandom()};
                step(1'($urandom_range(0, 3) != 0), a, 1, sel, d, "R2 R3 rand+wr");
            end else begin
                step(1'($urandom_range(0, 3) != 0), a, 0, 0, 0, "R2 R3 rand");
            end
        end

        // R1 reset returns boundaries to zero
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_lo = '0; m_hi = '0;
        check("R1 reset valid again", {63'h0, rsp_valid}, 64'h0);
        step(1, 64'h1000_0000, 0, 0, 0, "R1 low after reset");
        step(1, 64'h2_0000_0000, 0, 0, 0, "R1 high after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule